// File: doc/BRIEF.md
# Dual-Channel DMA Register Block

This block holds the software-visible control and status state for a pair of DMA channels. Channel 0 transmits and channel 1 receives. A simple 32-bit bus reaches the block with word accesses at byte offsets. Each channel owns a 0x30-byte window. Within that window are:

- a control word;
- a status word;
- a current-descriptor pointer;
- a tail-descriptor pointer;
- spare words that act as plain storage.

The descriptor-walking engine and the completion-coalescing counters sit outside the block. The block drives their control fields: run, completion threshold, delay count and the descriptor pointers. It also emits a threshold-reload pulse on every control write and a start pulse when the transmit tail is written. In the other direction it takes in their event pulses: completion, delay expiry, idle reached and halt. On each status read it folds in the live completion countdown and the live timer count. Each channel has a registered interrupt line. It goes high when a pending interrupt flag meets its enable bit in the control word.

A soft reset leaves the reset bit visible until the next control read. Tail-pointer mode is always reported as on. Writing the tail pointer takes a channel out of idle.

Top module: `dma_chan_regs`

## Requirements
- R1: After `rst_ni` deasserts, each channel's control reads 0x0001_0000, its status low half reads 0x0001 (halted only), and `irq_o` is 0.
- R2: For byte offset A, the channel is bit 0 of A/0x30 and the word index is (A mod 0x30)/4. Control is index 0, status 1, current descriptor 2 and tail 4. Indices 3 and 5..11 are plain read/write words. Offsets 0x60 and above alias channel 0.
- R3: Control bit 0 is run, bit 1 is tail mode and bit 2 is soft reset. Every control write stores bit 1 as 1, and the other written bits are kept as written.
- R4: A control write whose new value has the reset bit set (written, or still held from an earlier reset) has these effects:
  - status becomes 0x0001;
  - control becomes 0x0001_0000 with bit 2 held;
  - the held bit survives later control writes;
  - the next control read returns the value with bit 2 clear and clears it.
- R5: A control write with run set while the channel is not resetting clears status bits 0 (halted) and 1 (idle). While resetting, the channel stays halted.
- R6: A status read returns bits 15:0 as stored, bits 23:16 from that channel's byte of `cmpl_cnt_i` and bits 31:24 from that channel's byte of `tmr_cnt_i` (channel c uses bits 8c+7:8c).
- R7: Writing status clears each of bits 14:12 written as 1 and leaves every other stored status bit unchanged. An event that sets a flag in the same cycle wins over the clear.
- R8: `irq_o[c]` is high one cycle after the channel's stored status bits 14:12 AND its control bits 14:12 become nonzero, and low one cycle after they become zero.
- R9: A tail write clears the channel's idle bit. On channel 0 only, it also pulses `tx_start_o` for one cycle after the write.
- R10: Every control write to channel c, reset writes included, pulses `reload_o[c]` for exactly one cycle after the write.
- R11: Event pulses set status bits: completion sets bit 12, delay sets bit 13, idle sets bit 1 and halt sets bit 0.
- R12: The following outputs reflect the stored registers:
  - `run_o[c]` is control bit 0;
  - `thresh_o` byte c is control bits 23:16;
  - `delay_o` byte c is control bits 31:24;
  - `cur_desc_o` and `tail_desc_o` word c are the channel's pointer registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| ev_ioc_i | input | 2 | Completion event pulse per channel |
| ev_dly_i | input | 2 | Delay-expiry event pulse per channel |
| ev_idle_i | input | 2 | Engine reached tail, per channel |
| ev_halt_i | input | 2 | Engine halted, per channel |
| cmpl_cnt_i | input | 16 | Live completion countdown, one byte per channel |
| tmr_cnt_i | input | 16 | Live delay timer count, one byte per channel |
| irq_o | output | 2 | Registered interrupt per channel |
| run_o | output | 2 | Run bit per channel |
| reload_o | output | 2 | Threshold reload pulse per channel |
| thresh_o | output | 16 | Completion threshold, one byte per channel |
| delay_o | output | 16 | Delay count, one byte per channel |
| tx_start_o | output | 1 | Transmit engine start pulse |
| cur_desc_o | output | 64 | Current descriptor pointer, one word per channel |
| tail_desc_o | output | 64 | Tail descriptor pointer, one word per channel |

## Verification
The assertions watch the pulse outputs on every cycle:

- every control write yields exactly one reload pulse on the addressed channel, and no pulse comes without one;
- the transmit start pulse follows a channel 0 tail write and only that;
- the interrupt line falls quiet after a soft reset.

Only the bench's scenarios can show the register contents seen through reads. These include the held reset bit and its clear-on-read, the write-one-to-clear versus event race, the folded live counts, the address aliasing and the gating of interrupts by their enables.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int REG_W     = 32;
  localparam int CNT_W     = 8;
  localparam int WIN_BYTES = 'h30;
  localparam int WORDS     = WIN_BYTES / 4;
  localparam int IDX_W     = $clog2(WORDS);

  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_CUR  = 2;
  localparam int IDX_TAIL = 4;

  localparam int B_RUN  = 0;
  localparam int B_TMOD = 1;
  localparam int B_RST  = 2;

  localparam int S_HALT = 0;
  localparam int S_IDLE = 1;
  localparam int S_IOC  = 12;
  localparam int S_DLY  = 13;
  localparam int IRQ_LO = 12;
  localparam int IRQ_HI = 14;

  localparam logic [REG_W-1:0] CTRL_INIT = 32'h0001_0000;
  localparam logic [15:0]      STAT_INIT = 16'h0001;

  typedef struct packed {
    logic             ch;
    logic [IDX_W-1:0] idx;
  } dec_t;
endpackage

// File: rtl/dma_addr_dec.sv
module dma_addr_dec
  import dma_regs_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic [AW-1:0] addr_i,
  output dec_t          dec_o
);
  localparam logic [AW-1:0] WIN = AW'(WIN_BYTES);

  always_comb begin
    dec_o.ch  = 1'((addr_i / WIN) % AW'(2));
    dec_o.idx = IDX_W'((addr_i % WIN) >> 2);
  end
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_regs_pkg::*;
#(
  parameter bit IS_TX = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             ev_ioc_i,
  input  logic             ev_dly_i,
  input  logic             ev_idle_i,
  input  logic             ev_halt_i,
  input  logic [CNT_W-1:0] cmpl_cnt_i,
  input  logic [CNT_W-1:0] tmr_cnt_i,
  output logic [REG_W-1:0] rd_word_o,
  output logic             irq_o,
  output logic             run_o,
  output logic             reload_o,
  output logic             start_o,
  output logic [CNT_W-1:0] thresh_o,
  output logic [CNT_W-1:0] delay_o,
  output logic [REG_W-1:0] cur_o,
  output logic [REG_W-1:0] tail_o
);
  logic [REG_W-1:0] ctrl_q, ctrl_n, ctrl_wv;
  logic [15:0]      stat_q, stat_n;
  logic [REG_W-1:0] word_q [WORDS];
  logic             irq_q, reload_q, start_q;
  logic             ctrl_wr, ctrl_rd, stat_wr, tail_wr;

  assign ctrl_wr = wr_i && idx_i == IDX_W'(IDX_CTRL);
  assign ctrl_rd = rd_i && idx_i == IDX_W'(IDX_CTRL);
  assign stat_wr = wr_i && idx_i == IDX_W'(IDX_STAT);
  assign tail_wr = wr_i && idx_i == IDX_W'(IDX_TAIL);

  // Tail mode forced on; a held reset bit is carried into the new value
  assign ctrl_wv = wdata_i | (REG_W'(1) << B_TMOD) | (ctrl_q & (REG_W'(1) << B_RST));

  always_comb begin
    ctrl_n = ctrl_q;
    stat_n = stat_q;
    if (ctrl_wr) begin
      if (ctrl_wv[B_RST]) ctrl_n = CTRL_INIT | (REG_W'(1) << B_RST);
      else                ctrl_n = ctrl_wv;
    end else if (ctrl_rd) begin
      ctrl_n[B_RST] = 1'b0;
    end
    if (stat_wr) stat_n[IRQ_HI:IRQ_LO] = stat_q[IRQ_HI:IRQ_LO] & ~wdata_i[IRQ_HI:IRQ_LO];
    if (tail_wr) stat_n[S_IDLE] = 1'b0;
    if (ctrl_wr && !ctrl_wv[B_RST] && ctrl_wv[B_RUN]) begin
      stat_n[S_HALT] = 1'b0;
      stat_n[S_IDLE] = 1'b0;
    end
    // Events dominate clears
    if (ev_ioc_i)  stat_n[S_IOC]  = 1'b1;
    if (ev_dly_i)  stat_n[S_DLY]  = 1'b1;
    if (ev_idle_i) stat_n[S_IDLE] = 1'b1;
    if (ev_halt_i) stat_n[S_HALT] = 1'b1;
    if (ctrl_wr && ctrl_wv[B_RST]) stat_n = STAT_INIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_INIT;
      stat_q   <= STAT_INIT;
      irq_q    <= 1'b0;
      reload_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_n;
      stat_q   <= stat_n;
      irq_q    <= |(stat_q[IRQ_HI:IRQ_LO] & ctrl_q[IRQ_HI:IRQ_LO]);
      reload_q <= ctrl_wr;
      start_q  <= tail_wr && IS_TX;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    if (w == IDX_CTRL || w == IDX_STAT) begin : g_none
      assign word_q[w] = '0;
    end else begin : g_store
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           word_q[w] <= '0;
        else if (wr_i && idx_i == IDX_W'(w))   word_q[w] <= wdata_i;
      end
    end
  end

  always_comb begin
    rd_word_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (idx_i == IDX_W'(w)) rd_word_o = word_q[w];
    end
    if (idx_i == IDX_W'(IDX_CTRL)) rd_word_o = ctrl_q & ~(REG_W'(1) << B_RST);
    if (idx_i == IDX_W'(IDX_STAT)) rd_word_o = {tmr_cnt_i, cmpl_cnt_i, stat_q};
  end

  assign irq_o    = irq_q;
  assign run_o    = ctrl_q[B_RUN];
  assign reload_o = reload_q;
  assign start_o  = start_q;
  assign thresh_o = ctrl_q[23:16];
  assign delay_o  = ctrl_q[31:24];
  assign cur_o    = word_q[IDX_CUR];
  assign tail_o   = word_q[IDX_TAIL];
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  output logic [REG_W-1:0]     rdata_o,
  input  logic [1:0]           ev_ioc_i,
  input  logic [1:0]           ev_dly_i,
  input  logic [1:0]           ev_idle_i,
  input  logic [1:0]           ev_halt_i,
  input  logic [2*CNT_W-1:0]   cmpl_cnt_i,
  input  logic [2*CNT_W-1:0]   tmr_cnt_i,
  output logic [1:0]           irq_o,
  output logic [1:0]           run_o,
  output logic [1:0]           reload_o,
  output logic [2*CNT_W-1:0]   thresh_o,
  output logic [2*CNT_W-1:0]   delay_o,
  output logic                 tx_start_o,
  output logic [2*REG_W-1:0]   cur_desc_o,
  output logic [2*REG_W-1:0]   tail_desc_o
);
  localparam int NCH = 2;

  dec_t             dec;
  logic [REG_W-1:0] rd_word [NCH];
  logic [NCH-1:0]   start_w;
  logic [REG_W-1:0] rdata_q;

  dma_addr_dec #(.AW(AW)) u_dec (.addr_i(addr_i), .dec_o(dec));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = req_i && dec.ch == 1'(c);
    dma_chan_csr #(.IS_TX(c == 0)) u_csr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (sel && we_i),
      .rd_i       (sel && !we_i),
      .idx_i      (dec.idx),
      .wdata_i    (wdata_i),
      .ev_ioc_i   (ev_ioc_i[c]),
      .ev_dly_i   (ev_dly_i[c]),
      .ev_idle_i  (ev_idle_i[c]),
      .ev_halt_i  (ev_halt_i[c]),
      .cmpl_cnt_i (cmpl_cnt_i[c*CNT_W +: CNT_W]),
      .tmr_cnt_i  (tmr_cnt_i[c*CNT_W +: CNT_W]),
      .rd_word_o  (rd_word[c]),
      .irq_o      (irq_o[c]),
      .run_o      (run_o[c]),
      .reload_o   (reload_o[c]),
      .start_o    (start_w[c]),
      .thresh_o   (thresh_o[c*CNT_W +: CNT_W]),
      .delay_o    (delay_o[c*CNT_W +: CNT_W]),
      .cur_o      (cur_desc_o[c*REG_W +: REG_W]),
      .tail_o     (tail_desc_o[c*REG_W +: REG_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rd_word[dec.ch];
  end

  assign rdata_o    = rdata_q;
  assign tx_start_o = |start_w;  // only the transmit instance can pulse
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int AW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic          wr_rst_i,
  input logic [1:0]    irq_o,
  input logic [1:0]    reload_o,
  input logic          tx_start_o
);
  logic       a_ch;
  logic [3:0] a_idx;
  logic [1:0] ctrl_wr;
  logic       tail_wr0;

  always_comb begin
    a_ch     = 1'((addr_i / AW'(48)) % AW'(2));
    a_idx    = 4'((addr_i % AW'(48)) >> 2);
    ctrl_wr  = '0;
    if (req_i && we_i && a_idx == 4'd0) ctrl_wr[a_ch] = 1'b1;
    tail_wr0 = req_i && we_i && a_idx == 4'd4 && !a_ch;
  end

  for (genvar c = 0; c < 2; c++) begin : g_c
    AST_RELOAD_AFTER_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_wr[c] |=> reload_o[c]);  // R10
    AST_RELOAD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reload_o[c] |-> $past(ctrl_wr[c]));  // R10
    AST_IRQ_QUIET_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr[c] && wr_rst_i) |=> ##1 !irq_o[c]);  // R4
  end

  AST_TX_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_wr0 |=> tx_start_o);  // R9
  AST_TX_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(tail_wr0));  // R9
  AST_RELOAD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reload_o));  // R10
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wr_rst_i   (wdata_i[2]),
  .irq_o      (irq_o),
  .reload_o   (reload_o),
  .tx_start_o (tx_start_o)
);

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  localparam int AW = 7;

  logic        clk_i = 0, rst_ni = 0;
  logic        req_i = 0, we_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [1:0]  ev_ioc_i = 0, ev_dly_i = 0, ev_idle_i = 0, ev_halt_i = 0;
  logic [15:0] cmpl_cnt_i = 16'h2211, tmr_cnt_i = 16'h4433;
  logic [1:0]  irq_o, run_o, reload_o;
  logic [15:0] thresh_o, delay_o;
  logic        tx_start_o;
  logic [63:0] cur_desc_o, tail_desc_o;

  int checks = 0, errors = 0;
  logic [31:0] shadow [2][12];
  logic [15:0] stat_lo [2];

  dma_chan_regs #(.AW(AW)) dut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i); d = rdata_o; req_i = 0;
  endtask

  function automatic logic [31:0] exp_stat(input int c, input logic [15:0] lo);
    return {tmr_cnt_i[c*8 +: 8], cmpl_cnt_i[c*8 +: 8], lo};
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    rd(7'h00, d); chk("R1 ctrl0", d, 32'h0001_0000);
    chk("R1 irq", irq_o, 2'b00);
    rd(7'h04, d); chk("R1 R6 stat0", d, 32'h3311_0001);
    rd(7'h34, d); chk("R1 R6 stat1", d, 32'h4422_0001);
    // R3 tail mode forced
    wr(7'h00, 32'h0000_7000);
    rd(7'h00, d); chk("R3 ctrl forced bit1", d, 32'h0000_7002);
    chk("R12 run off", run_o[0], 1'b0);
    // R5 run clears halted/idle
    wr(7'h00, 32'h0000_7001);
    rd(7'h04, d); chk("R5 run clears halt", d, 32'h3311_0000);
    chk("R12 run on", run_o[0], 1'b1);
    // R11 R8 completion event -> irq
    @(negedge clk_i); ev_ioc_i = 2'b01;
    @(negedge clk_i); ev_ioc_i = 0;
    @(negedge clk_i); chk("R8 irq raised", irq_o[0], 1'b1);
    rd(7'h04, d); chk("R11 ioc bit", d, 32'h3311_1000);
    // R7 W1C behaviour
    wr(7'h04, 32'h0000_2000);
    rd(7'h04, d); chk("R7 other bit w1c", d, 32'h3311_1000);
    wr(7'h04, 32'hFFFF_0FFF);
    rd(7'h04, d); chk("R7 non-irq bits untouched", d, 32'h3311_1000);
    wr(7'h04, 32'h0000_1000);
    @(negedge clk_i); chk("R8 irq dropped", irq_o[0], 1'b0);
    rd(7'h04, d); chk("R7 ioc cleared", d, 32'h3311_0000);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = 7'h04; wdata_i = 32'h1000; ev_ioc_i = 2'b01;
    @(negedge clk_i); req_i = 0; we_i = 0; ev_ioc_i = 0;
    rd(7'h04, d); chk("R7 event beats clear", d, 32'h3311_1000);
    wr(7'h04, 32'h0000_1000);
    // R8 enable gating on channel 1
    @(negedge clk_i); ev_dly_i = 2'b10;
    @(negedge clk_i); ev_dly_i = 0;
    @(negedge clk_i); chk("R8 masked irq", irq_o[1], 1'b0);
    rd(7'h34, d); chk("R11 dly bit", d, 32'h4422_2001);
    wr(7'h30, 32'h0000_2000);
    chk("R10 reload ch1", reload_o, 2'b10);
    @(negedge clk_i); chk("R8 enabled irq", irq_o[1], 1'b1);
    // R4 soft reset
    wr(7'h00, 32'h0000_0004);
    chk("R10 reload on reset write", reload_o, 2'b01);
    wr(7'h00, 32'h0000_0001);
    rd(7'h04, d); chk("R5 still halted while resetting", d, 32'h3311_0001);
    rd(7'h00, d); chk("R4 read hides reset", d, 32'h0001_0000);
    chk("R12 thresh after reset", thresh_o[7:0], 8'h01);
    wr(7'h00, 32'h0000_0001);
    rd(7'h00, d); chk("R4 reset cleared by read", d, 32'h0000_0003);
    rd(7'h04, d); chk("R5 runs after reset read", d, 32'h3311_0000);
    // R9 R11 idle and tail
    @(negedge clk_i); ev_idle_i = 2'b01;
    @(negedge clk_i); ev_idle_i = 0;
    rd(7'h04, d); chk("R11 idle bit", d, 32'h3311_0002);
    wr(7'h10, 32'hABCD_0040);
    chk("R9 tx start", tx_start_o, 1'b1);
    @(negedge clk_i); chk("R9 tx start single", tx_start_o, 1'b0);
    rd(7'h04, d); chk("R9 tail clears idle", d, 32'h3311_0000);
    chk("R12 tail out", tail_desc_o[31:0], 32'hABCD_0040);
    wr(7'h40, 32'h0000_1111);
    chk("R9 rx tail no start", tx_start_o, 1'b0);
    @(negedge clk_i); ev_halt_i = 2'b01;
    @(negedge clk_i); ev_halt_i = 0;
    rd(7'h04, d); chk("R11 halt bit", d, 32'h3311_0001);
    // R2 alias window
    wr(7'h60, 32'h0);
    rd(7'h00, d); chk("R2 alias ctrl", d, 32'h0000_0002);
    // R12 fields
    wr(7'h30, 32'h0503_0000);
    chk("R12 thresh", thresh_o[15:8], 8'h03);
    chk("R12 delay", delay_o[15:8], 8'h05);
    // R2 random storage words and R6 live counts
    stat_lo[0] = 16'h0001; stat_lo[1] = 16'h2001;
    for (int c = 0; c < 2; c++) for (int w = 0; w < 12; w++) shadow[c][w] = 32'h0;
    shadow[0][4] = 32'hABCD_0040; shadow[1][4] = 32'h0000_1111;
    for (int i = 0; i < 60; i++) begin
      int c, w;
      c = $urandom % 2;
      w = 2 + ($urandom % 10);
      d = $urandom;
      wr(AW'(c * 48 + w * 4), d);
      shadow[c][w] = d;
    end
    for (int c = 0; c < 2; c++) begin
      for (int w = 2; w < 12; w++) begin
        rd(AW'(c * 48 + w * 4), d);
        chk($sformatf("R2 word c%0d w%0d", c, w), d, shadow[c][w]);
      end
      chk("R12 cur out", cur_desc_o[c*32 +: 32], shadow[c][2]);
    end
    for (int i = 0; i < 10; i++) begin
      int c;
      c = $urandom % 2;
      cmpl_cnt_i = 16'($urandom); tmr_cnt_i = 16'($urandom);
      rd(AW'(c * 48 + 4), d);
      chk("R6 live counts", d, exp_stat(c, stat_lo[c]));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule